// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This core switches byte-wide time slots between serial streams. Eight input streams each carry 32 channels per frame, with each channel eight bits long and sent most significant bit first. Every channel byte that arrives is stored in a data memory that holds two frames. While one half of the memory fills with the current frame, the outputs read the other half, which holds the last complete frame. A connection memory has one entry for each of the 256 output slots. Its low byte names the source slot as a 3-bit stream and a 5-bit channel. Its high part holds three flags: drive enable, message select and a control-stream bit.

A separate timing block supplies a bit-rate strobe (`bit_tick`) and a frame marker (`frame_start`). The marker is taken on the tick that carries bit 0 of channel 0. A processor bus gives access to the connection memory and to the live received data. An access starts on the first cycle in which the chip is selected and the strobe is high. Each output stream comes out as a data bit plus a drive-enable bit, and a global enable input gates all eight drive enables together. A control serial output carries one flag bit from each of the 256 connection entries every frame.

Top module: `tsi_switch`

## Requirements
- R1: In frame F, output stream s, channel c carries the byte received in frame F-1 on the stream/channel named by connection low entry {s,c} (bits 7:5 stream, bits 4:0 channel). Any source can feed any number of outputs. Output bit k of a channel appears on `st_out` one clock after the tick that carries input bit k at the same position.
- R2: High entry bit 2 is the per-channel drive enable. When it is 0, `st_oe` for that output channel stays low for all eight bits of the channel.
- R3: When high entry bit 1 (message select) is 1, the output channel sends the connection low byte itself instead of switched data.
- R4: While `ode` is low, all `st_oe` bits are low. While `ode` is high, each channel follows its own enable.
- R5: During tick (channel c, bit b), `ctl_out` is loaded with high entry bit 0 of location {b,c}. This gives 256 control bits per frame, and `ctl_out` holds its value between ticks.
- R6: A synchronous active-low reset clears `st_oe`, `ctl_out` and every high entry, and sets `ack_n` high.
- R7: A read with `addr[9:8]`=2 returns the byte last completed for input location `addr[7:0]`.
- R8: An access takes place on the first cycle with `cs_n` low and `ds` high, and `rw`=1 selects a read. `ack_n` goes low the next cycle and stays low until the strobe ends. `rdata` is valid and stable while `ack_n` is low.
- R9: `addr[9:8]`=0 selects the connection low byte and `addr[9:8]`=1 selects the high flags (data bits 2:0). Both can be written and read back.
- R10: If a connection entry is written on the same edge that fetches it for output, that channel still uses the old entry in the current frame and uses the new entry from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit cell |
| frame_start | input | 1 | Marks the tick of bit 0, channel 0 |
| st_in | input | 8 | Serial input streams |
| ode | input | 1 | Global output drive enable |
| cs_n | input | 1 | Chip select, active low |
| ds | input | 1 | Data strobe, active high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 10 | Region (9:8) and location (7:0) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| ack_n | output | 1 | Transfer acknowledge, active low |
| st_out | output | 8 | Serial output data |
| st_oe | output | 8 | Per-stream drive enable for the current bit |
| ctl_out | output | 1 | Control serial stream |

## Verification
A processor write to a connection entry can land on the same clock edge on which the output side fetches that entry at bit 0 of its channel. The bench sets up this collision by tracking the slot position and starting the write so that its first strobe cycle meets that fetch edge. The result is judged against the bench's model, which updates its shadow of the entry only after the edge. The redirected channel must carry the old source for the rest of that frame and the new source in the next frame.

// File: rtl/tsi_pkg.sv
// Shared types for the time-slot interchange core.
// Assumes: high connection entries are three flag bits, in the order below.
package tsi_pkg;

    // processor address regions, taken from the top two address bits
    typedef enum logic [1:0] {
        RGN_CONN = 2'd0,
        RGN_FLAG = 2'd1,
        RGN_LIVE = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    // high connection entry: drive enable, message select, control bit
    typedef struct packed {
        logic oe;
        logic msg;
        logic ctl;
    } hi_ent_t;

    localparam int HI_W = $bits(hi_ent_t);

endpackage

// File: rtl/tsi_timing.sv
// Slot position tracker. It turns the bit strobe and the frame marker into the
// current channel/bit position and chooses which data-memory half is written
// and which is read.
// Assumes: frame_start is only sampled together with bit_tick.
module tsi_timing #(
    parameter int N_CHANS = 32,
    parameter int BYTE_W  = 8,
    localparam int CH_W   = $clog2(N_CHANS),
    localparam int BIT_W  = $clog2(BYTE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             frame_start,
    output logic [CH_W-1:0]  cur_chan,
    output logic [BIT_W-1:0] cur_bit,
    output logic             wr_bank,
    output logic             rd_bank
);
    localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(N_CHANS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    logic [CH_W-1:0]  chan_q;
    logic [BIT_W-1:0] bit_q;
    logic             bank_q;
    logic             fs;

    assign fs       = frame_start & bit_tick;
    assign cur_chan = fs ? '0 : chan_q;
    assign cur_bit  = fs ? '0 : bit_q;
    assign wr_bank  = fs ? ~bank_q : bank_q;
    assign rd_bank  = ~wr_bank;

    // advance the position on every tick and swap memory halves at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            bit_q  <= '0;
            bank_q <= 1'b0;
        end else if (bit_tick) begin
            if (fs) bank_q <= ~bank_q;
            if (cur_bit == BIT_LAST) begin
                bit_q  <= '0;
                chan_q <= (cur_chan == CH_LAST) ? '0 : cur_chan + 1'b1;
            end else begin
                bit_q  <= cur_bit + 1'b1;
                chan_q <= cur_chan;
            end
        end
    end

    // R1
    bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_start) |=> (bank_q != $past(bank_q)));

    // R1
    bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && frame_start) |=> $stable(bank_q));

endmodule

// File: rtl/tsi_rx.sv
// Receive side. Shifts each input stream into a byte and writes every finished
// channel byte into a two-frame data memory. It provides one read port per
// output stream plus one for the processor, all reading the completed half.
// Assumes: serial bits arrive most significant bit first.
module tsi_rx #(
    parameter int N_STREAMS = 8,
    parameter int N_CHANS   = 32,
    parameter int BYTE_W    = 8,
    localparam int STR_W    = $clog2(N_STREAMS),
    localparam int CH_W     = $clog2(N_CHANS),
    localparam int BIT_W    = $clog2(BYTE_W),
    localparam int LOC_W    = STR_W + CH_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bit_tick,
    input  logic [N_STREAMS-1:0]                st_in,
    input  logic [CH_W-1:0]                     cur_chan,
    input  logic [BIT_W-1:0]                    cur_bit,
    input  logic                                wr_bank,
    input  logic                                rd_bank,
    input  logic [N_STREAMS-1:0][LOC_W-1:0]     tx_src,
    output logic [N_STREAMS-1:0][BYTE_W-1:0]    tx_byte,
    input  logic [LOC_W-1:0]                    cpu_loc,
    output logic [BYTE_W-1:0]                   cpu_byte
);
    localparam int N_LOC = N_STREAMS * N_CHANS;
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    logic [N_STREAMS-1:0][BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0]                dmem [2*N_LOC];
    logic                             byte_done;

    assign byte_done = bit_tick && (cur_bit == BIT_LAST);

    // collect serial bits of every stream into its byte register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (bit_tick) begin
            for (int s = 0; s < N_STREAMS; s++)
                shreg[s] <= {shreg[s][BYTE_W-2:0], st_in[s]};
        end
    end

    // store each completed channel byte in the half being filled
    always_ff @(posedge clk) begin
        if (byte_done) begin
            for (int s = 0; s < N_STREAMS; s++)
                dmem[{wr_bank, STR_W'(s), cur_chan}] <= {shreg[s][BYTE_W-2:0], st_in[s]};
        end
    end

    for (genvar g = 0; g < N_STREAMS; g++) begin : g_rd
        assign tx_byte[g] = dmem[{rd_bank, tx_src[g]}];
    end

    assign cpu_byte = dmem[{rd_bank, cpu_loc}];

endmodule

// File: rtl/tsi_cmem.sv
// Connection memory and processor bus. Low entries hold a source location or
// a message byte, high entries hold the three channel flags. An access is
// taken on the first strobe cycle, and it is acknowledged from the next cycle
// until the strobe ends. The block provides the entries of the current channel
// for every output stream, and the control flag for the current tick.
// Assumes: N_STREAMS equals BYTE_W, so that bit index b picks control location {b,c}.
module tsi_cmem
    import tsi_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int N_CHANS   = 32,
    parameter int BYTE_W    = 8,
    localparam int STR_W    = $clog2(N_STREAMS),
    localparam int CH_W     = $clog2(N_CHANS),
    localparam int BIT_W    = $clog2(BYTE_W),
    localparam int LOC_W    = STR_W + CH_W,
    localparam int ADDR_W   = LOC_W + 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cs_n,
    input  logic                              ds,
    input  logic                              rw,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [BYTE_W-1:0]                 wdata,
    output logic [BYTE_W-1:0]                 rdata,
    output logic                              ack_n,
    input  logic [CH_W-1:0]                   cur_chan,
    input  logic [BIT_W-1:0]                  cur_bit,
    output logic [N_STREAMS-1:0][BYTE_W-1:0]  lo_ent,
    output hi_ent_t [N_STREAMS-1:0]           hi_ent,
    output logic                              ctl_bit,
    output logic [LOC_W-1:0]                  live_loc,
    input  logic [BYTE_W-1:0]                 live_byte
);
    localparam int N_LOC = N_STREAMS * N_CHANS;

    logic [BYTE_W-1:0] lo_mem [N_LOC];
    hi_ent_t           hi_mem [N_LOC];
    logic              sel, sel_q, start;
    region_e           rgn;
    logic [LOC_W-1:0]  loc;

    assign sel      = !cs_n && ds;
    assign start    = sel && !sel_q;
    assign rgn      = region_e'(addr[ADDR_W-1 -: 2]);
    assign loc      = addr[LOC_W-1:0];
    assign live_loc = loc;

    // track the strobe, drive the acknowledge and capture read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            ack_n <= 1'b1;
            rdata <= '0;
        end else begin
            sel_q <= sel;
            ack_n <= !sel;
            if (start && rw) begin
                case (rgn)
                    RGN_CONN: rdata <= lo_mem[loc];
                    RGN_FLAG: rdata <= {{(BYTE_W-HI_W){1'b0}}, hi_mem[loc]};
                    RGN_LIVE: rdata <= live_byte;
                    default:  rdata <= '0;
                endcase
            end
        end
    end

    // apply processor writes; reset clears all entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LOC; i++) begin
                lo_mem[i] <= '0;
                hi_mem[i] <= '0;
            end
        end else if (start && !rw) begin
            if (rgn == RGN_CONN) lo_mem[loc] <= wdata;
            if (rgn == RGN_FLAG) hi_mem[loc] <= hi_ent_t'(wdata[HI_W-1:0]);
        end
    end

    for (genvar g = 0; g < N_STREAMS; g++) begin : g_ent
        assign lo_ent[g] = lo_mem[{STR_W'(g), cur_chan}];
        assign hi_ent[g] = hi_mem[{STR_W'(g), cur_chan}];
    end

    assign ctl_bit = hi_mem[{STR_W'(cur_bit), cur_chan}].ctl;

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !$past(ack_n)) |-> $stable(rdata));

    // R6
    ack_reset_chk: assert property (@(posedge clk)
        !rst_n |=> ack_n);

endmodule

// File: rtl/tsi_tx.sv
// Transmit side. At bit 0 of each channel it takes either the switched byte or
// the message byte for every output stream, together with that channel's drive
// enable, and then shifts the byte out. It also registers the control bit for
// each tick.
// Assumes: the byte reads from the data memory and connection memory are combinational.
module tsi_tx
    import tsi_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int N_CHANS   = 32,
    parameter int BYTE_W    = 8,
    localparam int STR_W    = $clog2(N_STREAMS),
    localparam int CH_W     = $clog2(N_CHANS),
    localparam int BIT_W    = $clog2(BYTE_W),
    localparam int LOC_W    = STR_W + CH_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bit_tick,
    input  logic [BIT_W-1:0]                  cur_bit,
    input  logic [N_STREAMS-1:0][BYTE_W-1:0]  lo_ent,
    input  hi_ent_t [N_STREAMS-1:0]           hi_ent,
    input  logic                              ctl_bit,
    output logic [N_STREAMS-1:0][LOC_W-1:0]   tx_src,
    input  logic [N_STREAMS-1:0][BYTE_W-1:0]  tx_byte,
    input  logic                              ode,
    output logic [N_STREAMS-1:0]              st_out,
    output logic [N_STREAMS-1:0]              st_oe,
    output logic                              ctl_out
);
    logic [N_STREAMS-1:0][BYTE_W-1:0] pick;
    logic [N_STREAMS-1:0][BYTE_W-1:0] sh;
    logic [N_STREAMS-1:0]             oe_q;
    logic                             load;

    assign load = bit_tick && (cur_bit == '0);

    for (genvar g = 0; g < N_STREAMS; g++) begin : g_sel
        assign tx_src[g] = lo_ent[g][LOC_W-1:0];
        assign pick[g]   = hi_ent[g].msg ? lo_ent[g] : tx_byte[g];
        assign st_out[g] = sh[g][BYTE_W-1];
    end

    assign st_oe = oe_q & {N_STREAMS{ode}};

    // load a new byte at channel start, otherwise shift; register the control bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            oe_q    <= '0;
            ctl_out <= 1'b0;
        end else if (bit_tick) begin
            ctl_out <= ctl_bit;
            for (int s = 0; s < N_STREAMS; s++) begin
                if (load) begin
                    sh[s]   <= pick[s];
                    oe_q[s] <= hi_ent[s].oe;
                end else begin
                    sh[s]   <= sh[s] << 1;
                end
            end
        end
    end

    // R2
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && cur_bit != '0) |=> $stable(oe_q));

    // R6
    oe_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (oe_q == '0));

    // R5
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(ctl_out));

    // R1
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(st_out));

endmodule

// File: rtl/tsi_switch.sv
// Top of the time-slot interchange core. It connects the position tracker,
// the receive memory, the connection memory with its processor bus, and the
// transmit serializer.
// Assumes: bit_tick and frame_start come from an external timing block.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int N_CHANS   = 32,
    parameter int BYTE_W    = 8,
    localparam int STR_W    = $clog2(N_STREAMS),
    localparam int CH_W     = $clog2(N_CHANS),
    localparam int BIT_W    = $clog2(BYTE_W),
    localparam int LOC_W    = STR_W + CH_W,
    localparam int ADDR_W   = LOC_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 frame_start,
    input  logic [N_STREAMS-1:0] st_in,
    input  logic                 ode,
    input  logic                 cs_n,
    input  logic                 ds,
    input  logic                 rw,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [BYTE_W-1:0]    rdata,
    output logic                 ack_n,
    output logic [N_STREAMS-1:0] st_out,
    output logic [N_STREAMS-1:0] st_oe,
    output logic                 ctl_out
);
    logic [CH_W-1:0]                  cur_chan;
    logic [BIT_W-1:0]                 cur_bit;
    logic                             wr_bank, rd_bank;
    logic [N_STREAMS-1:0][LOC_W-1:0]  tx_src;
    logic [N_STREAMS-1:0][BYTE_W-1:0] tx_byte;
    logic [N_STREAMS-1:0][BYTE_W-1:0] lo_ent;
    hi_ent_t [N_STREAMS-1:0]          hi_ent;
    logic                             ctl_bit;
    logic [LOC_W-1:0]                 live_loc;
    logic [BYTE_W-1:0]                live_byte;

    tsi_timing #(.N_CHANS(N_CHANS), .BYTE_W(BYTE_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
        .cur_chan(cur_chan), .cur_bit(cur_bit), .wr_bank(wr_bank), .rd_bank(rd_bank)
    );

    tsi_rx #(.N_STREAMS(N_STREAMS), .N_CHANS(N_CHANS), .BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .st_in(st_in),
        .cur_chan(cur_chan), .cur_bit(cur_bit), .wr_bank(wr_bank), .rd_bank(rd_bank),
        .tx_src(tx_src), .tx_byte(tx_byte), .cpu_loc(live_loc), .cpu_byte(live_byte)
    );

    tsi_cmem #(.N_STREAMS(N_STREAMS), .N_CHANS(N_CHANS), .BYTE_W(BYTE_W)) u_cmem (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds(ds), .rw(rw), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .cur_chan(cur_chan),
        .cur_bit(cur_bit), .lo_ent(lo_ent), .hi_ent(hi_ent), .ctl_bit(ctl_bit),
        .live_loc(live_loc), .live_byte(live_byte)
    );

    tsi_tx #(.N_STREAMS(N_STREAMS), .N_CHANS(N_CHANS), .BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cur_bit(cur_bit),
        .lo_ent(lo_ent), .hi_ent(hi_ent), .ctl_bit(ctl_bit), .tx_src(tx_src),
        .tx_byte(tx_byte), .ode(ode), .st_out(st_out), .st_oe(st_oe), .ctl_out(ctl_out)
    );

    // R4
    ode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ode && $stable(ode)) |-> (st_oe == '0));

endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b1;
    logic       frame_start = 1'b0;
    logic [7:0] st_in = '0;
    logic       ode = 1'b1;
    logic       cs_n = 1'b1, ds = 1'b0, rw = 1'b1;
    logic [9:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack_n;
    logic [7:0] st_out, st_oe;
    logic       ctl_out;

    always #5 clk = ~clk;

    tsi_switch uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
        .st_in(st_in), .ode(ode), .cs_n(cs_n), .ds(ds), .rw(rw), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .st_out(st_out),
        .st_oe(st_oe), .ctl_out(ctl_out)
    );

    typedef struct {
        int              f;
        int              c;
        logic [7:0][7:0] d;
        logic [7:0]      oe;
        logic [7:0]      dv;
        logic [7:0]      msg;
    } item_t;

    item_t      dq[$];
    logic       cq[$];
    logic [7:0] sh_lo [256];
    logic [2:0] sh_hi [256];
    int nchk = 0, nfail = 0;
    int fr = 0, drv_c = 0, drv_b = 0, coll_f = -10;
    bit go = 0;

    function automatic logic [7:0] pat(int f, int s, int c);
        return 8'((f * 29 + s * 37 + c * 11 + 7) & 255) ^ 8'hA5;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // bus access, the write or read lands on the posedge after the first negedge
    task automatic bus(bit rd, logic [1:0] rgn, logic [7:0] loc, logic [7:0] wd,
                       output logic [7:0] rv);
        @(negedge clk);
        cs_n = 1'b0; ds = 1'b1; rw = rd; addr = {rgn, loc}; wdata = wd;
        @(posedge clk); #1;
        if (!rd && rgn == 2'd0) sh_lo[loc] = wd;
        if (!rd && rgn == 2'd1) sh_hi[loc] = wd[2:0];
        @(negedge clk);
        check(ack_n == 1'b0, "R8 ack low", ack_n, 0);
        rv = rdata;
        cs_n = 1'b1; ds = 1'b0;
        @(negedge clk);
        check(ack_n == 1'b1, "R8 ack released", ack_n, 1);
    endtask

    // stream driver: drives serial inputs and pushes expected items
    initial begin
        item_t it;
        logic [7:0] b8, lo;
        logic [2:0] hi;
        logic ctlx;
        wait (go);
        forever begin
            for (int c = 0; c < 32; c++) begin
                for (int b = 0; b < 8; b++) begin
                    @(negedge clk);
                    frame_start = (c == 0 && b == 0);
                    for (int s = 0; s < 8; s++) begin
                        b8 = pat(fr, s, c);
                        st_in[s] = b8[7-b];
                    end
                    drv_c = c; drv_b = b;
                    if (b == 0) begin
                        it.f = fr; it.c = c;
                        for (int s = 0; s < 8; s++) begin
                            lo = sh_lo[s*32+c];
                            hi = sh_hi[s*32+c];
                            it.oe[s]  = hi[2];
                            it.msg[s] = hi[1];
                            it.dv[s]  = hi[1] || (fr >= 1);
                            it.d[s]   = hi[1] ? lo : pat(fr - 1, int'(lo[7:5]), int'(lo[4:0]));
                        end
                    end
                    hi = sh_hi[b*32+c];
                    ctlx = hi[0];
                    @(posedge clk); #1;
                    if (b == 0) dq.push_back(it);
                    cq.push_back(ctlx);
                end
            end
            fr++;
        end
    end

    // monitor: pops expected items and compares against outputs
    initial begin
        item_t cur;
        logic [7:0] got [8];
        int bn = 0;
        bit act = 0;
        logic ce;
        string tag;
        forever begin
            @(negedge clk);
            if (bn == 0) begin
                act = (dq.size() > 0);
                if (act) cur = dq.pop_front();
            end
            if (act) begin
                for (int s = 0; s < 8; s++) begin
                    got[s] = {got[s][6:0], st_out[s]};
                    check(st_oe[s] == (cur.oe[s] & ode), ode ? "R2 drive enable" : "R4 global off",
                          st_oe[s], cur.oe[s] & ode);
                end
                if (bn == 7) begin
                    for (int s = 0; s < 8; s++) begin
                        if (cur.dv[s]) begin
                            if (cur.msg[s]) tag = "R3 message byte";
                            else if (s == 1 && cur.c == 7 && (cur.f == coll_f || cur.f == coll_f + 1))
                                tag = "R10 fetch collision";
                            else tag = "R1 switched byte";
                            check(got[s] == cur.d[s], tag, got[s], cur.d[s]);
                        end
                    end
                end
                bn = (bn + 1) % 8;
            end
            if (cq.size() > 0) begin
                ce = cq.pop_front();
                check(ctl_out == ce, "R5 control stream", ctl_out, ce);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] exp;
        for (int i = 0; i < 256; i++) begin sh_lo[i] = '0; sh_hi[i] = '0; end
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        check(st_oe == 8'h00, "R6 st_oe after reset", st_oe, 0);
        check(ctl_out == 1'b0, "R6 ctl_out after reset", ctl_out, 0);
        check(ack_n == 1'b1, "R6 ack_n after reset", ack_n, 1);
        bus(1, 2'd1, 8'h55, 8'h00, rv);
        check(rv == 8'h00, "R6 flags cleared", rv, 0);

        // program a permutation with drive enabled and a sprinkled control bit
        for (int o = 0; o < 256; o++) begin
            bus(0, 2'd0, 8'((o * 5 + 3) & 255), 8'h00, rv);
        end
        for (int o = 0; o < 256; o++) begin
            bus(0, 2'd1, 8'(o), {5'd0, 1'b1, 1'b0, 1'((o % 3) == 0)}, rv);
        end
        // the loops above wrote location (o*5+3) with 0; redo low entries per output
        for (int o = 0; o < 256; o++) bus(0, 2'd0, 8'(o), 8'((o * 5 + 3) & 255), rv);
        bus(0, 2'd0, 8'd10, 8'h3C, rv);          // output s0 c10: message byte
        bus(0, 2'd1, 8'd10, 8'b110, rv);
        bus(0, 2'd1, 8'd20, 8'b001, rv);         // output s0 c20: not driven
        bus(0, 2'd0, 8'd70, 8'd77, rv);          // two outputs share one source
        bus(0, 2'd0, 8'd71, 8'd77, rv);

        // R9 readback
        bus(1, 2'd0, 8'd10, 8'h00, rv);
        check(rv == 8'h3C, "R9 low readback", rv, 8'h3C);
        bus(1, 2'd1, 8'd20, 8'h00, rv);
        check(rv == 8'h01, "R9 flag readback", rv, 1);
        bus(1, 2'd0, 8'd71, 8'h00, rv);
        check(rv == 8'd77, "R9 low readback 2", rv, 77);

        go = 1;
        repeat (3 * 256) @(posedge clk);

        // R4: global enable off for over a frame, then on again
        @(posedge clk); #2 ode = 1'b0;
        repeat (300) @(posedge clk);
        #2 ode = 1'b1;
        repeat (100) @(posedge clk);

        // R7: live read mid-frame
        forever begin
            @(posedge clk); #1;
            if (drv_c == 10 && drv_b == 2) break;
        end
        exp = pat(fr - 1, 2, 5);
        bus(1, 2'd2, {3'd2, 5'd5}, 8'h00, rv);
        check(rv == exp, "R7 live channel read", rv, exp);

        // R10: write output s1 c7 on the edge that fetches it
        repeat (300) @(posedge clk);
        forever begin
            @(posedge clk); #1;
            if (drv_c == 6 && drv_b == 7) break;
        end
        coll_f = fr;
        bus(0, 2'd0, 8'd39, {3'd6, 5'd20}, rv);

        repeat (700) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule